// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Conditioner

This block takes a fast oscillator clock and produces the processor clock at one third of that rate. The processor clock is high for one oscillator period in three. The block also produces a peripheral clock at half the processor-clock rate with an even duty cycle, and a buffered copy of the oscillator. All of its state is kept in flops clocked by the oscillator. Every output except the buffered copy comes from a register.

The block also conditions two asynchronous control inputs for the processor. The first is an active-low reset request, which becomes an active-high processor reset. The second is a pair of ready requests, each enabled by its own active-low enable, which become one processor ready. Both paths go through two synchronizer stages. These stages advance only at the start of a processor-clock period, so both outputs change only on a rising edge of the processor clock. The divider and the peripheral clock keep running while the processor reset is asserted, so the processor sees clock edges during reset.

A chip-level power-on reset (`sys_rst_n`) puts the block's own flops into a known state. It is separate from the processor reset request that the block conditions.

Top module: `cpu_clk_cond`

## Requirements
- R1: `cpu_clk` has a period of exactly three `osc_clk` cycles and is high for exactly one of them.
- R2: `per_clk` inverts on every rising edge of `cpu_clk` and at no other time, giving a period of six `osc_clk` cycles with an even duty cycle.
- R3: `osc_buf` follows `osc_clk` level for level.
- R4: `cpu_reset` changes only on a rising edge of `cpu_clk`. A low level on `rst_req_n` that covers no rising edge of `cpu_clk` has no effect.
- R5: After `rst_req_n` changes between rising edges of `cpu_clk`, `cpu_reset` still shows the old value after the next rising edge and shows the new value (high while the request is low) after the edge that follows.
- R6: The qualified ready is `(rdy_a & ~rdy_a_en_n) | (rdy_b & ~rdy_b_en_n)`. A source whose enable is high has no effect.
- R7: `cpu_ready` changes only on a rising edge of `cpu_clk`. After the qualified ready changes between edges, `cpu_ready` keeps the old value after the next rising edge and takes the new value after the edge that follows.
- R8: While `cpu_reset` is high, `cpu_clk` and `per_clk` keep the timing of R1 and R2.
- R9: While `sys_rst_n` is low, `cpu_clk`, `per_clk` and `cpu_ready` are 0 and `cpu_reset` is 1. The first `osc_clk` rising edge after `sys_rst_n` goes high drives `cpu_clk` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; clocks every flop in the block |
| sys_rst_n | input | 1 | Chip power-on reset, active low, asynchronous |
| rst_req_n | input | 1 | Asynchronous processor reset request, active low |
| rdy_a | input | 1 | Asynchronous ready request, source A |
| rdy_a_en_n | input | 1 | Enable for source A, active low |
| rdy_b | input | 1 | Asynchronous ready request, source B |
| rdy_b_en_n | input | 1 | Enable for source B, active low |
| cpu_clk | output | 1 | Processor clock, oscillator rate divided by three, one-third duty cycle |
| per_clk | output | 1 | Peripheral clock, half the processor-clock rate, 50% duty cycle |
| osc_buf | output | 1 | Buffered oscillator clock |
| cpu_reset | output | 1 | Synchronized processor reset, active high |
| cpu_ready | output | 1 | Synchronized, qualified processor ready |

## Verification
The assertions check on every oscillator cycle that the processor clock keeps its one-high-two-low pattern and that the peripheral clock inverts only where a processor-clock period begins. They also check that the reset and ready outputs move only on those boundaries and hold still between them. Only the bench's scenarios can show the end-to-end behaviour. This covers the two-period latency of each synchronizer, the ready truth table over the enable combinations, and a short reset pulse that falls between boundaries being ignored. It also covers the divider still running during an asserted reset and the reset values.

// File: rtl/clkcond_pkg.sv
package clkcond_pkg;

  // Next state of a counter that wraps from `last` back to zero.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  // Ready request after each source has been gated by its active-low enable.
  function automatic logic ready_qualify(input logic ra, input logic ra_en_n,
                                         input logic rb, input logic rb_en_n);
    return (ra & ~ra_en_n) | (rb & ~rb_en_n);
  endfunction

endpackage

// File: rtl/osc_divider.sv
module osc_divider
  import clkcond_pkg::*;
#(
  parameter int DIV_RATIO = 3
) (
  input  logic osc_clk,
  input  logic sys_rst_n,
  output logic cpu_clk,
  output logic per_clk,
  output logic prd_start
);
  localparam int CW   = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam int LAST = DIV_RATIO - 1;

  logic [CW-1:0] phase_q;

  // The edge that closes phase LAST opens the next processor-clock period.
  assign prd_start = (phase_q == CW'(LAST));

  always_ff @(posedge osc_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      phase_q <= CW'(LAST);
      cpu_clk <= 1'b0;
      per_clk <= 1'b0;
    end else begin
      phase_q <= CW'(wrap_inc(int'(phase_q), LAST));
      cpu_clk <= prd_start;
      if (prd_start) per_clk <= ~per_clk;
    end
  end

  AST_CLK_ONE_THIRD: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    $rose(cpu_clk) |=> !cpu_clk ##1 !cpu_clk ##1 cpu_clk); // R1
  AST_CLK_SINGLE_HIGH: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    cpu_clk |=> !cpu_clk); // R1
  AST_PCLK_ON_RISE: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    !$stable(per_clk) |-> $rose(cpu_clk)); // R2
  AST_PCLK_EVERY_RISE: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    $rose(cpu_clk) |-> !$stable(per_clk)); // R2

endmodule

// File: rtl/period_sync.sv
module period_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic osc_clk,
  input  logic sys_rst_n,
  input  logic adv,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge osc_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)  chain_q <= {STAGES{RST_VAL}};
    else if (adv)    chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  AST_SYNC_HOLDS: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    !adv |=> $stable(q)); // R7

endmodule

// File: rtl/cpu_clk_cond.sv
module cpu_clk_cond
  import clkcond_pkg::*;
#(
  parameter int DIV_RATIO   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic sys_rst_n,
  input  logic rst_req_n,
  input  logic rdy_a,
  input  logic rdy_a_en_n,
  input  logic rdy_b,
  input  logic rdy_b_en_n,
  output logic cpu_clk,
  output logic per_clk,
  output logic osc_buf,
  output logic cpu_reset,
  output logic cpu_ready
);
  logic prd_start;
  logic rdy_qual;

  assign osc_buf  = osc_clk;
  assign rdy_qual = ready_qualify(rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n);

  osc_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .osc_clk  (osc_clk),
    .sys_rst_n(sys_rst_n),
    .cpu_clk  (cpu_clk),
    .per_clk  (per_clk),
    .prd_start(prd_start)
  );

  period_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .osc_clk  (osc_clk),
    .sys_rst_n(sys_rst_n),
    .adv      (prd_start),
    .d        (~rst_req_n),
    .q        (cpu_reset)
  );

  period_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .osc_clk  (osc_clk),
    .sys_rst_n(sys_rst_n),
    .adv      (prd_start),
    .d        (rdy_qual),
    .q        (cpu_ready)
  );

  AST_RESET_ON_EDGE: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    !$stable(cpu_reset) |-> $rose(cpu_clk)); // R4
  AST_READY_ON_EDGE: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    !$stable(cpu_ready) |-> $rose(cpu_clk)); // R7
  AST_CLK_IN_RESET: assert property (@(posedge osc_clk) disable iff (!sys_rst_n)
    (cpu_reset && $rose(cpu_clk)) |=> ##2 cpu_clk); // R8

endmodule

// File: tb/cpu_clk_cond_bench.sv
module cpu_clk_cond_bench;
  localparam int OSC_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic osc_clk = 1'b0;
  logic sys_rst_n, rst_req_n, rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n;
  logic cpu_clk, per_clk, osc_buf, cpu_reset, cpu_ready;

  int tests = 0;
  int fails = 0;

  always #(OSC_PERIOD/2) osc_clk = ~osc_clk;

  cpu_clk_cond u_cpu_clk_cond (
    .osc_clk(osc_clk), .sys_rst_n(sys_rst_n), .rst_req_n(rst_req_n),
    .rdy_a(rdy_a), .rdy_a_en_n(rdy_a_en_n), .rdy_b(rdy_b), .rdy_b_en_n(rdy_b_en_n),
    .cpu_clk(cpu_clk), .per_clk(per_clk), .osc_buf(osc_buf),
    .cpu_reset(cpu_reset), .cpu_ready(cpu_ready)
  );

  // Vector: {rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n, expected ready} (R6)
  localparam logic [4:0] VEC [8] = '{
    5'b10011, 5'b11000, 5'b01101, 5'b11110,
    5'b00101, 5'b10101, 5'b00000, 5'b11010
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Return at the falling osc edge right after cpu_clk has gone high.
  task automatic next_rise();
    do @(negedge osc_clk); while (cpu_clk !== 1'b1);
  endtask

  task automatic check_clocks(input string req);
    int n;
    logic pv;
    next_rise();
    pv = per_clk;
    n = 0;
    do begin @(negedge osc_clk); n++; end while (cpu_clk !== 1'b1);
    chk(n == 3, req, n, 3);
    chk(per_clk == ~pv, req, per_clk, ~pv);
    n = 0;
    for (int i = 0; i < 6; i++) begin @(negedge osc_clk); n += cpu_clk; end
    chk(n == 2, req, n, 2);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge osc_clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic prev;
    sys_rst_n = 1'b0; rst_req_n = 1'b1;
    rdy_a = 1'b0; rdy_a_en_n = 1'b1; rdy_b = 1'b0; rdy_b_en_n = 1'b1;
    repeat (3) @(negedge osc_clk);
    // R9 reset state
    chk(cpu_clk == 0,   "R9 clk",   cpu_clk, 0);
    chk(per_clk == 0,   "R9 pclk",  per_clk, 0);
    chk(cpu_reset == 1, "R9 reset", cpu_reset, 1);
    chk(cpu_ready == 0, "R9 ready", cpu_ready, 0);
    sys_rst_n = 1'b1;
    @(negedge osc_clk);
    chk(cpu_clk == 1,   "R9 first edge", cpu_clk, 1);
    chk(cpu_reset == 1, "R5 release pending", cpu_reset, 1);
    next_rise();
    chk(cpu_reset == 0, "R5 release done", cpu_reset, 0);

    // R1 R2 divider timing
    check_clocks("R1/R2 divider");

    // R3 buffered oscillator
    @(negedge osc_clk); chk(osc_buf == 0, "R3 low", osc_buf, 0);
    @(posedge osc_clk); #1; chk(osc_buf == 1, "R3 high", osc_buf, 1);

    // R6 R7 ready table
    next_rise();
    prev = 1'b0;
    for (int i = 0; i < 8; i++) begin
      {rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n} = VEC[i][4:1];
      next_rise();
      chk(cpu_ready == prev, "R7 latency", cpu_ready, prev);
      next_rise();
      chk(cpu_ready == VEC[i][0], "R6 qualify", cpu_ready, VEC[i][0]);
      prev = VEC[i][0];
    end

    // R7 change between edges not visible early
    rdy_a = 1'b1; rdy_a_en_n = 1'b0;
    @(negedge osc_clk);
    chk(cpu_ready == 0, "R7 no early change", cpu_ready, 0);
    next_rise(); next_rise();
    chk(cpu_ready == 1, "R7 arrives", cpu_ready, 1);

    // R4 short pulse between boundaries ignored
    next_rise();
    rst_req_n = 1'b0;
    @(negedge osc_clk);
    rst_req_n = 1'b1;
    next_rise(); chk(cpu_reset == 0, "R4 pulse ignored", cpu_reset, 0);
    next_rise(); chk(cpu_reset == 0, "R4 pulse ignored", cpu_reset, 0);

    // R5 assertion latency
    rst_req_n = 1'b0;
    next_rise(); chk(cpu_reset == 0, "R5 assert pending", cpu_reset, 0);
    next_rise(); chk(cpu_reset == 1, "R5 asserted", cpu_reset, 1);

    // R8 clocks run during reset
    check_clocks("R8 clocks in reset");
    chk(cpu_reset == 1, "R8 reset held", cpu_reset, 1);

    // R5 release latency
    rst_req_n = 1'b1;
    next_rise(); chk(cpu_reset == 1, "R5 release pending", cpu_reset, 1);
    next_rise(); chk(cpu_reset == 0, "R5 released", cpu_reset, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule